// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Controller

This block turns two logic commands into the high-side and low-side gate enables of one half-bridge. Two control schemes are available through a mode input. In the protected scheme, equal commands select a switch (both low picks the low side, both high picks the high side), unequal commands switch everything off, and every turn-on is held back by a programmable dead time counted in clock cycles. In the direct scheme, each command drives one gate on its own with no delay. Both gates may then be on together. The caller owns that choice, and the block passes it through.

Two undervoltage flags from a separate fault supervisor gate the outputs. A supply undervoltage removes both gates, and a bootstrap undervoltage removes only the high side. An active-low wake input acts as the block's reset. While wake is low, the block is asleep: both enables are low and a high-impedance indicator tells the pad drivers to float the gates.

A command that changes while a turn-on is still counting down restarts the count for the side that is now requested. The side that was pending before is never switched on. Turn-off always takes one clock edge.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While wake is low, gate_hi and gate_lo are 0 and hiz is 1, at once and with no clock edge, whatever the other inputs are.
- R2: With direct_mode=0, commands 00 select the low side and commands 11 select the high side. The selected enable stays 0 for L clock edges after the edge that samples the new command and is 1 after edge L+1. L is the effective dead count.
- R3: With direct_mode=0, gate_hi and gate_lo are never 1 in the same cycle. Unequal commands (01 or 10) give 0 on both at the first edge. Between one side turning off and the other turning on there are at least L cycles.
- R4: With direct_mode=1, gate_hi follows cmd_a and gate_lo follows cmd_b one edge later. This includes both being 1 together.
- R5: In either mode, an enable that is no longer requested drops at the first edge that samples the change.
- R6: A dead_cnt of 0 uses the DEFAULT_DEAD parameter as L. Any other value of dead_cnt is used as L directly.
- R7: uv_supply=1 forces both enables to 0 at the next edge. In dead-time mode, once the flag clears, a turn-on waits a full dead time again.
- R8: uv_boot=1 forces gate_hi to 0 at the next edge and leaves gate_lo working normally in both modes.
- R9: In dead-time mode, a change of command during a countdown restarts the count for the newly requested side. The earlier pending side is never asserted.
- R10: Entering dead-time mode from direct mode first clears both enables, then applies a full dead time before any turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| wake | input | 1 | Active-high enable; low is sleep and asynchronous reset |
| direct_mode | input | 1 | 1 = direct drive, 0 = dead-time scheme |
| cmd_a | input | 1 | Command 1 (high side in direct mode) |
| cmd_b | input | 1 | Command 2 (low side in direct mode) |
| dead_cnt | input | CNT_W | Dead time in clock cycles; 0 selects DEFAULT_DEAD |
| uv_supply | input | 1 | Supply undervoltage flag |
| uv_boot | input | 1 | Bootstrap undervoltage flag |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| hiz | output | 1 | Gates floated (sleep) indicator |

## Verification
The bench builds the block with CNT_W=8 and DEFAULT_DEAD=40, in place of the 1500-cycle default of 12 µs at 125 MHz. This keeps the zero-setting fallback within a short run and still makes it clearly longer than the explicit count of 5 used elsewhere. With the explicit count of 5, the bench can check a turn-on one edge before and exactly at its expiry, restart a countdown halfway through, and watch the off-to-on gap across every side change.

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int CNT_W        = 11,
  parameter int DEFAULT_DEAD = 1500
) (
  input  logic             clk,
  input  logic             wake,
  input  logic             direct_mode,
  input  logic             cmd_a,
  input  logic             cmd_b,
  input  logic [CNT_W-1:0] dead_cnt,
  input  logic             uv_supply,
  input  logic             uv_boot,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             hiz
);

  localparam logic [CNT_W-1:0] DFLT = CNT_W'(DEFAULT_DEAD);

  typedef enum logic [1:0] {S_NONE = 2'd0, S_HI = 2'd1, S_LO = 2'd2} side_t;

  side_t            side_q, side_d, pend_q, pend_d, tgt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, lo_q, hi_d, lo_d;
  logic [CNT_W-1:0] load_val;

  assign load_val = (dead_cnt == '0) ? DFLT : dead_cnt;

  always_comb begin
    if (uv_supply || cmd_a != cmd_b) tgt = S_NONE;
    else if (cmd_a)                  tgt = uv_boot ? S_NONE : S_HI;
    else                             tgt = S_LO;
  end

  always_comb begin
    side_d = side_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (direct_mode) begin
      side_d = S_NONE;
      pend_d = S_NONE;
      cnt_d  = '0;
    end else if (tgt != pend_q) begin
      pend_d = tgt;
      side_d = S_NONE;
      cnt_d  = (tgt == S_NONE) ? '0 : load_val;
    end else if (pend_q != S_NONE && side_q != pend_q) begin
      if (cnt_q <= CNT_W'(1)) side_d = pend_q;
      else                    cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  assign hi_d = direct_mode ? (cmd_a & ~uv_supply & ~uv_boot) : (side_d == S_HI);
  assign lo_d = direct_mode ? (cmd_b & ~uv_supply)            : (side_d == S_LO);

  always_ff @(posedge clk or negedge wake) begin
    if (!wake) begin
      side_q <= S_NONE;
      pend_q <= S_NONE;
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      side_q <= side_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign gate_hi = hi_q;
  assign gate_lo = lo_q;
  assign hiz     = ~wake;

  a_r1_sleep_low: assert property (@(posedge clk)
    !wake |-> (!gate_hi && !gate_lo));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!wake)
    (!direct_mode && !$past(direct_mode)) |-> !(gate_hi && gate_lo));

  a_r4_direct_follow: assert property (@(posedge clk) disable iff (!wake)
    ($past(direct_mode) && !$past(uv_supply) && !$past(uv_boot) && $past(wake))
      |-> (gate_hi == $past(cmd_a) && gate_lo == $past(cmd_b)));

  a_r5_fast_off_hi: assert property (@(posedge clk) disable iff (!wake)
    (!$past(direct_mode) && !($past(cmd_a) && $past(cmd_b))) |-> !gate_hi);

  a_r5_fast_off_lo: assert property (@(posedge clk) disable iff (!wake)
    (!$past(direct_mode) && ($past(cmd_a) || $past(cmd_b))) |-> !gate_lo);

  a_r7_supply_off: assert property (@(posedge clk) disable iff (!wake)
    $past(uv_supply) |-> (!gate_hi && !gate_lo));

  a_r8_boot_off: assert property (@(posedge clk) disable iff (!wake)
    $past(uv_boot) |-> !gate_hi);

  a_r2_no_instant_on: assert property (@(posedge clk) disable iff (!wake)
    (!direct_mode && !$past(direct_mode) && $rose(gate_hi)) |-> $past(!gate_hi && !gate_lo));

endmodule

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;
  localparam int CW = 8;
  localparam int DFL = 40;

  logic clk = 1'b0;
  logic wake, direct_mode, cmd_a, cmd_b, uv_supply, uv_boot;
  logic [CW-1:0] dead_cnt;
  logic gate_hi, gate_lo, hiz;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hb_gate_ctrl #(.CNT_W(CW), .DEFAULT_DEAD(DFL)) uut (
    .clk(clk), .wake(wake), .direct_mode(direct_mode), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .dead_cnt(dead_cnt), .uv_supply(uv_supply), .uv_boot(uv_boot),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz));

  // {req[4], mode, a, b, uvs, uvb, dead[8], wait[8], exp_hi, exp_lo}
  localparam int NV = 20;
  localparam logic [26:0] VEC [NV] = '{
    {4'd4,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'd5, 8'd1,  1'b1,1'b0}, // R4
    {4'd4,  1'b1,1'b1,1'b1,1'b0,1'b0, 8'd5, 8'd1,  1'b1,1'b1}, // R4 both on
    {4'd5,  1'b1,1'b0,1'b1,1'b0,1'b0, 8'd5, 8'd1,  1'b0,1'b1}, // R5
    {4'd8,  1'b1,1'b1,1'b1,1'b0,1'b1, 8'd5, 8'd1,  1'b0,1'b1}, // R8
    {4'd7,  1'b1,1'b1,1'b1,1'b1,1'b0, 8'd5, 8'd1,  1'b0,1'b0}, // R7
    {4'd10, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd5,  1'b0,1'b0}, // R10
    {4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd1,  1'b0,1'b1}, // R2
    {4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 8'd5, 8'd1,  1'b0,1'b0}, // R3
    {4'd2,  1'b0,1'b1,1'b1,1'b0,1'b0, 8'd5, 8'd5,  1'b0,1'b0}, // R2
    {4'd2,  1'b0,1'b1,1'b1,1'b0,1'b0, 8'd5, 8'd1,  1'b1,1'b0}, // R2
    {4'd8,  1'b0,1'b1,1'b1,1'b0,1'b1, 8'd5, 8'd1,  1'b0,1'b0}, // R8
    {4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1, 8'd5, 8'd6,  1'b0,1'b1}, // R8
    {4'd7,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'd5, 8'd1,  1'b0,1'b0}, // R7
    {4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd5,  1'b0,1'b0}, // R7
    {4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd1,  1'b0,1'b1}, // R7
    {4'd9,  1'b0,1'b1,1'b1,1'b0,1'b0, 8'd5, 8'd3,  1'b0,1'b0}, // R9
    {4'd9,  1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd5,  1'b0,1'b0}, // R9
    {4'd9,  1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5, 8'd1,  1'b0,1'b1}, // R9
    {4'd6,  1'b0,1'b1,1'b1,1'b0,1'b0, 8'd0, 8'd40, 1'b0,1'b0}, // R6
    {4'd6,  1'b0,1'b1,1'b1,1'b0,1'b0, 8'd0, 8'd1,  1'b1,1'b0}  // R6
  };

  task automatic check(input int req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: {hi,lo,hiz} actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // R3 gap and overlap monitor in dead-time mode
  int gap = 0;
  int last_side = 0;
  logic prev_dm = 1'b1;
  logic prev_hi = 1'b0, prev_lo = 1'b0;
  always @(negedge clk) begin
    if (!finished && wake === 1'b1) begin
      if (direct_mode || prev_dm) begin
        last_side = 0; gap = 0;
      end else begin
        int eff;
        eff = (dead_cnt == 0) ? DFL : int'(dead_cnt);
        if (gate_hi && gate_lo) begin
          n_chk++; n_bad++;
          $display("FAIL R3: overlap actual=11 expected=not 11 at %0t", $time);
        end
        if ((gate_hi && !prev_hi && last_side == 2) || (gate_lo && !prev_lo && last_side == 1)) begin
          n_chk++;
          if (gap < eff) begin
            n_bad++;
            $display("FAIL R3: gap actual=%0d expected>=%0d", gap, eff);
          end
        end
        if (gate_hi) begin last_side = 1; gap = 0; end
        else if (gate_lo) begin last_side = 2; gap = 0; end
        else gap++;
      end
      prev_dm = direct_mode;
      prev_hi = gate_hi;
      prev_lo = gate_lo;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wake = 1'b0; direct_mode = 1'b1; cmd_a = 1'b1; cmd_b = 1'b1;
    uv_supply = 1'b0; uv_boot = 1'b0; dead_cnt = 8'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, {gate_hi, gate_lo, hiz}, 3'b001); // R1 reset state
    cmd_a = 1'b0; cmd_b = 1'b0;
    wake = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      direct_mode = v[22]; cmd_a = v[21]; cmd_b = v[20];
      uv_supply = v[19]; uv_boot = v[18]; dead_cnt = v[17:10];
      repeat (int'(v[9:2])) @(posedge clk);
      @(negedge clk);
      check(int'(v[26:23]), {gate_hi, gate_lo, hiz}, {v[1], v[0], 1'b0});
    end
    // R1: sleep acts at once, no clock edge
    #1 wake = 1'b0;
    #1 check(1, {gate_hi, gate_lo, hiz}, 3'b001);
    @(negedge clk);
    wake = 1'b1;
    dead_cnt = 8'd5;
    repeat (1) @(posedge clk);
    @(negedge clk);
    check(2, {gate_hi, gate_lo, hiz}, 3'b000); // R2 fresh dead time after wake
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(2, {gate_hi, gate_lo, hiz}, 3'b100);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule